// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This drawing stage turns one-bit-per-pixel glyph data into 8-bit pixels in a linear frame buffer. Software first loads the colours, the plane mask, the per-word X and Y increments and a horizontal span: a row, a first column and an inclusive last column. It then writes a 32-bit font word. The engine walks the word from its most significant bit. For each pixel it picks the foreground or the background colour and writes that pixel to a simple memory port at byte address `row * PITCH + column`. The write merges with the old byte under the plane mask.

All writes go through one port with a ready signal. While a word is being expanded the port stalls, so a write is held off and never dropped. When a word is done, the span origin moves by the programmed increments. This lets a stream of font words paint a long glyph row without reloading the origin. A span shorter than 32 pixels uses only the leading bits of the word.

Top module: `glyph_expand`

## Requirements
- R1: After reset the engine is idle: `wr_ready` is 1, `status` is 0 and `mem_we` is 0.
- R2: Writing a font word (select code 8) starts expansion. The first pixel goes to the current first column and takes bit 31. Each following pixel takes the next lower bit at the next column, on the row held in the row register.
- R3: A bit at 1 writes the foreground colour (select 0) and a bit at 0 writes the background colour (select 1).
- R4: Each pixel is written as `(old & ~mask) | (colour & mask)`. Here `old` is `mem_rdata` at the pixel's address and `mask` is the plane mask (select 2).
- R5: If the last column (select 7) minus the first column (select 6) plus one is below 32, exactly that many pixels are written, using only the top bits of the word.
- R6: A span wider than 32 columns writes exactly 32 pixels.
- R7: After a font word is finished, the first column grows by the X increment (select 3) and the row by the Y increment (select 4). The row register is select 5. The last column is left unchanged.
- R8: If the last column is below the first column, the font word is consumed and no pixel is written. The origin still advances as in R7, and the engine stays ready in the next cycle.
- R9: While pixels are being written, `status` bit 28 is 1 and `wr_ready` is 0. A write offered then is held until `wr_ready` returns.
- R10: Pixels are written one per clock on consecutive addresses. A word of N pixels keeps the engine busy for exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register or font word write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_sel | input | 4 | Target: 0 fg, 1 bg, 2 mask, 3 X inc, 4 Y inc, 5 row, 6 first col, 7 last col, 8 font word |
| wr_data | input | 32 | Write data (low bits used for narrow targets) |
| status | output | 32 | Bit 28 is busy, other bits 0 |
| mem_we | output | 1 | Pixel write strobe |
| mem_addr | output | AW | Pixel byte address |
| mem_rdata | input | 8 | Current byte at mem_addr (combinational read) |
| mem_wdata | output | 8 | Merged pixel value |

## Verification
The font word patterns are chosen so that each one separates a different failure. A word with only its two end bits set shows whether bit 31 lands on the first column and bit 0 on the last column. A word whose top byte differs from its lower bytes, drawn over an 8-pixel span, exposes the use of the wrong end of the word. A span of 41 columns shows whether the pixel count is clamped. A reversed span, followed by a normal word with no origin reload, checks both that nothing is written and that the origin still moved. A narrow plane mask over a pre-filled memory separates a true merge from a plain overwrite. Back-to-back words with a busy-cycle count check the stall and the one-pixel-per-clock rate.

// File: rtl/glyph_expand.sv
module glyph_expand #(
  parameter int PITCH = 64,
  parameter int AW    = 16,
  parameter int XW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [3:0]    wr_sel,
  input  logic [31:0]   wr_data,
  output logic [31:0]   status,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    mem_wdata
);
  localparam int WORD = 32;
  localparam int CW   = $clog2(WORD) + 1;

  logic [7:0]    fg, bg, pmask;
  logic [XW-1:0] inc_x, inc_y, row, col0, col1, cur_x;
  logic [31:0]   bits;
  logic [CW-1:0] left;
  logic          busy;

  logic [XW:0]   span;
  logic [CW-1:0] npix;
  logic          accept;
  logic [31:0]   addr_full;
  logic [7:0]    colour;

  assign accept   = wr_valid && !busy;
  assign wr_ready = !busy;
  assign status   = {3'b000, busy, 28'd0};
  assign span     = {1'b0, col1} - {1'b0, col0} + 1'b1;
  assign npix     = (col1 < col0) ? '0 :
                    (span > (XW+1)'(WORD)) ? CW'(WORD) : CW'(span);

  assign colour    = bits[31] ? fg : bg;
  assign addr_full = 32'(row) * 32'(PITCH) + 32'(cur_x);
  assign mem_addr  = addr_full[AW-1:0];
  assign mem_we    = busy;
  assign mem_wdata = (mem_rdata & ~pmask) | (colour & pmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg <= '0; bg <= '0; pmask <= '0;
      inc_x <= '0; inc_y <= '0; row <= '0; col0 <= '0; col1 <= '0;
      cur_x <= '0; bits <= '0; left <= '0; busy <= 1'b0;
    end else if (accept) begin
      case (wr_sel)
        4'd0: fg    <= wr_data[7:0];
        4'd1: bg    <= wr_data[7:0];
        4'd2: pmask <= wr_data[7:0];
        4'd3: inc_x <= wr_data[XW-1:0];
        4'd4: inc_y <= wr_data[XW-1:0];
        4'd5: row   <= wr_data[XW-1:0];
        4'd6: col0  <= wr_data[XW-1:0];
        4'd7: col1  <= wr_data[XW-1:0];
        4'd8: begin
          if (npix == '0) begin
            col0 <= col0 + inc_x;
            row  <= row + inc_y;
          end else begin
            busy  <= 1'b1;
            bits  <= wr_data;
            left  <= npix;
            cur_x <= col0;
          end
        end
        default: ;
      endcase
    end else if (busy) begin
      bits  <= bits << 1;
      cur_x <= cur_x + 1'b1;
      left  <= left - 1'b1;
      if (left == CW'(1)) begin
        busy <= 1'b0;
        col0 <= col0 + inc_x;
        row  <= row + inc_y;
      end
    end
  end

  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_len <= '0;
    else        run_len <= mem_we ? run_len + 1'b1 : '0;

  p_idle_reset_r1: assert property (@(posedge clk) !rst_n |-> !mem_we);
  p_colour_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & pmask) == (fg & pmask)) || ((mem_wdata & pmask) == (bg & pmask)));
  p_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata ^ mem_rdata) & ~pmask) == 8'd0);
  p_max_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (CW+1)'(WORD));
  p_reversed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_sel == 4'd8 && col1 < col0) |=> !mem_we && wr_ready);
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_valid && wr_sel == 4'd8));
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 1'b1);
endmodule

// File: tb/glyph_expand_bench.sv
`timescale 1ns/1ps
module glyph_expand_bench;
  localparam int PITCH = 64;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [3:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;

  always #2.5 clk = ~clk;

  glyph_expand #(.PITCH(PITCH), .AW(AW), .XW(16)) u_glyph_expand (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .status(status), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata));

  logic [7:0] ram [4096];
  logic [7:0] model [4096];
  assign mem_rdata = ram[mem_addr[11:0]];
  always @(posedge clk) if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_addr[$];
  int exp_data[$];
  string exp_tag[$];

  int m_fg, m_bg, m_pm, m_ix, m_iy, m_row, m_c0, m_c1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_addr.size() == 0) begin
        check(0, "R5 unexpected pixel write", int'(mem_addr), -1);
      end else begin
        int a, d;
        string t;
        a = exp_addr.pop_front(); d = exp_data.pop_front(); t = exp_tag.pop_front();
        check(int'(mem_addr) == a, {t, " addr"}, int'(mem_addr), a);
        check(int'(mem_wdata) == d, {t, " data"}, int'(mem_wdata), d);
      end
    end
  end

  task automatic wr(input int sel, input int data);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_sel = 4'(sel); wr_data = 32'(data);
    @(negedge clk);
    wr_valid = 1'b0;
    case (sel)
      0: m_fg = data & 8'hff;
      1: m_bg = data & 8'hff;
      2: m_pm = data & 8'hff;
      3: m_ix = data & 16'hffff;
      4: m_iy = data & 16'hffff;
      5: m_row = data & 16'hffff;
      6: m_c0 = data & 16'hffff;
      7: m_c1 = data & 16'hffff;
      default: ;
    endcase
  endtask

  function automatic int npix();
    if (m_c1 < m_c0) return 0;
    if (m_c1 - m_c0 + 1 > 32) return 32;
    return m_c1 - m_c0 + 1;
  endfunction

  task automatic font(input logic [31:0] w, input string tag);
    int n;
    n = npix();
    for (int i = 0; i < n; i++) begin
      int a, c, nv;
      a = (m_row * PITCH + m_c0 + i) & 16'hffff;
      c = w[31-i] ? m_fg : m_bg;
      nv = (model[a & 12'hfff] & ~m_pm & 8'hff) | (c & m_pm);
      model[a & 12'hfff] = 8'(nv);
      exp_addr.push_back(a); exp_data.push_back(nv); exp_tag.push_back(tag);
    end
    m_c0 = (m_c0 + m_ix) & 16'hffff;
    m_row = (m_row + m_iy) & 16'hffff;
    wr(8, int'(w));
  endtask

  task automatic drain(input string tag);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    check(exp_addr.size() == 0, tag, exp_addr.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ram[i] = 8'(i * 37 + 5);
      model[i] = 8'(i * 37 + 5);
    end
    m_fg = 0; m_bg = 0; m_pm = 0; m_ix = 0; m_iy = 0; m_row = 0; m_c0 = 0; m_c1 = 0;
    repeat (3) @(negedge clk);
    check(wr_ready == 1'b1, "R1 ready after reset", int'(wr_ready), 1);
    check(status == 32'd0, "R1 status after reset", int'(status), 0);
    check(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready && status == 0 && !mem_we, "R1 idle out of reset", int'(status), 0);

    // R2 R3: full word, end bits set
    wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hFF); wr(3, 32); wr(4, 0);
    wr(5, 2); wr(6, 0); wr(7, 31);
    font(32'h8000_0001, "R2 R3 full word");
    drain("R2 full word drained");

    // R7: origin advanced, no reload of first column
    wr(7, 63);
    font(32'h1234_5678, "R7 advanced by X inc");
    drain("R7 drained");

    // R5: partial span uses top bits
    wr(6, 5); wr(7, 12);
    font(32'hF00F_FFFF, "R5 partial span");
    drain("R5 drained");

    // R4: plane mask merge
    wr(2, 8'h0F); wr(0, 8'hFF); wr(1, 8'h00); wr(5, 4); wr(6, 3); wr(7, 18);
    font(32'hAAAA_0000, "R4 plane mask");
    drain("R4 drained");

    // R6: long span clamps to 32
    wr(2, 8'hFF); wr(0, 8'h11); wr(1, 8'h22); wr(5, 6); wr(6, 0); wr(7, 40);
    font(32'hC3C3_5A5A, "R6 long span");
    drain("R6 drained");

    // R8: reversed span, then R7 row/col advance
    wr(3, 7); wr(4, 1); wr(5, 8); wr(6, 10); wr(7, 3);
    font(32'hFFFF_FFFF, "R8 reversed");
    check(wr_ready == 1'b1, "R8 ready after reversed", int'(wr_ready), 1);
    check(status == 32'd0, "R8 not busy after reversed", int'(status), 0);
    drain("R8 no pixels");
    wr(7, 30);
    font(32'h0F00_0000, "R7 R8 origin moved");
    drain("R7 row and column moved");

    // R9 R10: stall and one pixel per clock
    wr(3, 8); wr(4, 0); wr(5, 10); wr(6, 0); wr(7, 7);
    font(32'h9100_0000, "R10 first word");
    check(wr_ready == 1'b0, "R9 ready low while busy", int'(wr_ready), 0);
    check(status[28] == 1'b1, "R9 busy bit", int'(status[28]), 1);
    wr(7, 15);
    begin
      int c;
      c = 0;
      font(32'h7E00_0000, "R9 held word");
      while (!wr_ready) begin c++; @(negedge clk); end
      check(c == 8, "R10 busy cycles", c, 8);
    end
    drain("R9 drained");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule